// File: doc/BRIEF.md
# Smooth Calibration Pulse Adjuster

This block runs on a slow reference clock. On each cycle it emits a count-enable value for a downstream prescaler. The value is 1 on an ordinary cycle, 0 when a pulse is dropped and 2 when a pulse is added. This lets the effective tick rate be trimmed in fine steps across a long calibration window.

A free-running window counter sets the positions of all corrections:

- Dropped pulses are spread evenly by decoding the lowest set bit of the window counter.
- Added pulses fall at a fixed stride.
- The add function is switched off whenever the asynchronous prescaler setting is too small to absorb it.

Top module: `cal_pulse_trim`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the window counter to zero. The counter then advances by one per clock and wraps after 2^WIN_W cycles (default 2^20).
- R2: `step` is 1 on a cycle with no correction, 0 on a dropped cycle and 2 on an added cycle. The value 3 never appears.
- R3: Bit k of `minus_trim` (k = 0..CORR_W-1) drops a pulse on each cycle where window counter bit WIN_W-1-k is the lowest set bit. With the defaults, bit 0 drops at count 0x80000 only, and bit 8 drops wherever the low 12 bits equal 0x800.
- R4: Over one full window the number of dropped pulses equals the value of `minus_trim` (0 to 511).
- R5: When the plus correction is in effect, one pulse is added on every cycle whose low INS_SHIFT counter bits are all zero (every 2^11 cycles by default). This adds 2^(WIN_W-INS_SHIFT) pulses per window, which is 512 by default.
- R6: When `async_div` is below PSC_MIN (3), `plus_trim` is ignored and no pulse is added. This holds even if `plus_trim` was already high.
- R7: A drop and an add that fall on the same cycle cancel each other, and `step` is 1. With the defaults this happens where bit 8 coincides with an add point.
- R8: The sum of `step` over one full window equals 2^WIN_W - `minus_trim` + 512 × (effective plus bit). This gives a net offset of -511 to +512 pulses.
- R9: A change on `minus_trim`, `plus_trim` or `async_div` applies to the current counter value with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| minus_trim | input | CORR_W (9) | Number of pulses to drop per window |
| plus_trim | input | 1 | Request to add pulses |
| async_div | input | PSC_W (7) | Asynchronous prescaler setting, used for gating |
| step | output | 2 | Increment for the downstream prescaler: 0, 1 or 2 |

## Verification
The assertions assume that the window counter length leaves at least one bit below the lowest drop tap, so WIN_W exceeds CORR_W. They also assume the correction inputs are steady values sampled at the clock, with no X on them after reset.

The bench drives inputs only at falling edges, always with defined values, and never lets reset glitch within a cycle. To fit full windows in a short run, the bench uses a 14-bit window with a 5-bit add stride. This keeps the ratio of 512 add points per window and the coincidence between the top drop tap and the add points.

// File: rtl/cal_pulse_trim.sv
module cal_pulse_trim #(
  parameter int WIN_W     = 20,
  parameter int CORR_W    = 9,
  parameter int INS_SHIFT = 11,
  parameter int PSC_W     = 7,
  parameter int PSC_MIN   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CORR_W-1:0] minus_trim,
  input  logic              plus_trim,
  input  logic [PSC_W-1:0]  async_div,
  output logic [1:0]        step
);

  localparam logic [WIN_W-1:0] INS_MASK = {WIN_W{1'b1}} >> (WIN_W - INS_SHIFT);

  logic [WIN_W-1:0]  win_cnt;
  logic [CORR_W-1:0] tap;
  logic              plus_eff, add_hit, drop_hit;

  always_ff @(posedge clk) begin
    if (rst) win_cnt <= '0;
    else     win_cnt <= win_cnt + 1'b1;
  end

  for (genvar k = 0; k < CORR_W; k++) begin : g_tap
    localparam int B = WIN_W - 1 - k;
    localparam logic [WIN_W-1:0] LOWM = {WIN_W{1'b1}} >> (WIN_W - B);
    assign tap[k] = win_cnt[B] && ((win_cnt & LOWM) == '0);
  end

  assign plus_eff = plus_trim && (async_div >= PSC_W'(PSC_MIN));
  assign add_hit  = plus_eff && ((win_cnt & INS_MASK) == '0);
  assign drop_hit = |(tap & minus_trim);

  always_comb begin
    unique case ({add_hit, drop_hit})
      2'b10:   step = 2'd2;
      2'b01:   step = 2'd0;
      default: step = 2'd1;
    endcase
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> win_cnt == '0);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (win_cnt == {WIN_W{1'b1}}) |=> (win_cnt == '0));
  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (rst) step != 2'd3);
  // R3
  drop_one_tap_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(tap));
  // R3
  drop_needs_trim_chk: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd0) |-> (minus_trim != '0 && win_cnt != '0));
  // R6
  plus_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (async_div < PSC_W'(PSC_MIN)) |-> (step != 2'd2));
  // R5
  add_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd2) |-> (plus_trim && win_cnt[INS_SHIFT-1:0] == '0));

endmodule

// File: tb/tb_cal_pulse_trim.sv
module tb_cal_pulse_trim;
  localparam int W  = 14;
  localparam int CW = 9;
  localparam int IS = 5;
  localparam int PW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] minus_trim = '0;
  logic plus_trim = 1'b0;
  logic [PW-1:0] async_div = 7'd7;
  logic [1:0] step;
  int total = 0, bad = 0, n = 0;

  cal_pulse_trim #(.WIN_W(W), .CORR_W(CW), .INS_SHIFT(IS), .PSC_W(PW), .PSC_MIN(3)) dut (
    .clk(clk), .rst(rst), .minus_trim(minus_trim), .plus_trim(plus_trim),
    .async_div(async_div), .step(step));

  always #4 clk = ~clk;

  function automatic int exp_step(int idx, logic [CW-1:0] m, logic p, logic [PW-1:0] a);
    int c, lsb, ins, drp;
    c = idx % (1 << W);
    ins = (p && a >= 3 && (c % (1 << IS)) == 0) ? 1 : 0;
    drp = 0;
    lsb = -1;
    for (int b = W - 1; b >= 0; b--) if (c[b]) lsb = b;
    if (lsb >= 0 && (W - 1 - lsb) < CW && m[W-1-lsb]) drp = 1;
    return 1 + ins - drp;
  endfunction

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; n = 0;
  endtask

  // Runs one full window, checking every cycle against the model and the sum.
  task automatic run_window(string req, logic [CW-1:0] m, logic p, logic [PW-1:0] a,
                            output int sum, output int mism);
    minus_trim = m; plus_trim = p; async_div = a;
    do_reset();
    sum = 0; mism = 0;
    for (int i = 0; i < (1 << W); i++) begin
      #1;
      sum += int'(step);
      if (int'(step) != exp_step(n, m, p, a)) begin
        if (mism == 0) $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, n, step, exp_step(n, m, p, a));
        mism++;
      end
      @(negedge clk); n++;
    end
    chk({req, " per-cycle positions"}, mism, 0);
  endtask

  task automatic t_reset();
    minus_trim = '0; plus_trim = 1'b1; async_div = 7'd7;
    do_reset();
    repeat (37) @(negedge clk);
    do_reset();
    #1 chk("R1 counter cleared (add at count 0)", step, 2);
    @(negedge clk); #1 chk("R1 counter advanced", step, 1);
  endtask

  task automatic t_window(string req, logic [CW-1:0] m, logic p, logic [PW-1:0] a);
    int s, mm, pe;
    pe = (p && a >= 3) ? 1 : 0;
    run_window(req, m, p, a, s, mm);
    chk({req, " R8 window sum"}, s, (1 << W) - int'(m) + 512 * pe);
  endtask

  task automatic t_single_drop();
    minus_trim = 9'd1; plus_trim = 1'b0; async_div = 7'd7;
    do_reset();
    repeat ((1 << (W - 1)) - 1) @(negedge clk);
    #1 chk("R3 no drop just before midpoint", step, 1);
    @(negedge clk); #1 chk("R3 bit0 drops at midpoint", step, 0);
    @(negedge clk); #1 chk("R3 no drop after midpoint", step, 1);
  endtask

  task automatic t_coincide();
    minus_trim = 9'h100; plus_trim = 1'b1; async_div = 7'd7;
    do_reset();
    repeat (1 << IS) @(negedge clk);
    #1 chk("R7 drop and add cancel", step, 1);
    plus_trim = 1'b0; #1 chk("R7 same point drop alone", step, 0);
    async_div = 7'd2; plus_trim = 1'b1; #1 chk("R6 plus ignored low divider", step, 0);
  endtask

  task automatic t_live_change();
    minus_trim = '0; plus_trim = 1'b0; async_div = 7'd7;
    do_reset();
    #1 chk("R9 no add when plus off", step, 1);
    plus_trim = 1'b1; #1 chk("R9 plus applies at once", step, 2);
    async_div = 7'd2; #1 chk("R6 plus dropped when divider < 3", step, 1);
    async_div = 7'd3; #1 chk("R6 plus restored at divider 3", step, 2);
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_drop();
    t_coincide();
    t_live_change();
    t_window("R2 R4 plain", 9'd0, 1'b0, 7'd7);
    t_window("R3 R4 max minus", 9'h1FF, 1'b0, 7'd7);
    t_window("R5 R7 mixed plus", 9'h155, 1'b1, 7'd7);
    t_window("R6 plus gated", 9'h0A3, 1'b1, 7'd2);
    t_window("R5 R7 top tap", 9'h100, 1'b1, 7'd3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule